// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a target device has left stuck, typically with SDA held low partway through a byte after a reset. It runs before the bus controller is handed the pins. When `start` is pulsed, it looks at the synchronized SCL and SDA levels. If both lines already read high, it reports success at once and never touches SCL.

If either line is low, the block clocks SCL to walk the stuck target through the rest of its byte. It produces a fixed number of pulses. In each pulse, SCL is pulled low for a programmable number of ticks and then released for a programmable number of ticks. SDA is never driven. After the last pulse, the block waits for both lines to read high. If they are still not both high when a tick-counted timeout expires, it finishes with an error and reports the levels the lines had at that moment.

All timing is counted in `tick` pulses, so the same logic works at any core clock. The tick is normally a one-microsecond strobe. The open-drain SCL pad is driven low whenever `scl_drive_low` is high.

Top module: `i2c_bus_clear`

## Requirements
- R1: When `start` is seen in idle and both synchronized lines are high, `done` is high on the next clock. `err_busy` is 0, and `scl_drive_low` stays 0 throughout.
- R2: When `start` is seen in idle and either synchronized line is low, `scl_drive_low` makes exactly PULSE_COUNT low pulses (default 9) before `done`.
- R3: Each low pulse of `scl_drive_low` lasts exactly LOW_TICKS tick-qualified cycles (default 50).
- R4: After each low pulse, SCL is released for exactly HIGH_TICKS tick-qualified cycles (default 50) before the next pulse or before polling starts.
- R5: After the pulses, when both synchronized lines read high within the timeout, `done` rises. `err_busy` is 0, and `last_scl` and `last_sda` are both 1.
- R6: When polling has consumed TIMEOUT_TICKS ticks (default 200000) without both lines high, `done` rises with `err_busy` = 1. At that point `last_scl` and `last_sda` hold the synchronized line levels, with 1 meaning high.
- R7: A `start` that arrives while a recovery is in progress is ignored. The run still produces PULSE_COUNT pulses and exactly one `done`.
- R8: `done` is a single-cycle pulse. `err_busy`, `last_scl` and `last_sda` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing strobe, one cycle wide, that advances all interval counters |
| start | input | 1 | Request a bus-clear sequence (accepted only in idle) |
| scl_in | input | 1 | Raw SCL pad level |
| sda_in | input | 1 | Raw SDA pad level |
| scl_drive_low | output | 1 | Open-drain enable: 1 pulls SCL low |
| done | output | 1 | One-cycle completion pulse |
| err_busy | output | 1 | 1 if the last run timed out with the bus still not idle |
| last_scl | output | 1 | Synchronized SCL level captured at completion |
| last_sda | output | 1 | Synchronized SDA level captured at completion |

## Verification
The bench sweeps every combination of stuck line, release point (early, mid-train, after the last pulse, mid-poll, never) and tick rate. It models the open-drain bus so that a design which miscounts pulses, stretches a low or released phase by one tick, or lets time advance without a tick will show a wrong count at the pins.

In the timeout runs, the bench counts every tick from the last pulse to `done`. An off-by-one in the timeout compare, or a poll that starts before the final release phase, is therefore reported. A clean bus must finish on the very next cycle with no SCL activity. A second `start` injected mid-run must not restart the pulse train or produce a second `done`. After completion, the error flag and the captured levels must stay steady.

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int PULSE_COUNT   = 9,
  parameter int LOW_TICKS     = 50,
  parameter int HIGH_TICKS    = 50,
  parameter int TIMEOUT_TICKS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_drive_low,
  output logic done,
  output logic err_busy,
  output logic last_scl,
  output logic last_sda
);

  localparam int MAXA = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int MAXT = (MAXA > TIMEOUT_TICKS) ? MAXA : TIMEOUT_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int PW   = $clog2(PULSE_COUNT + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_POLL} state_t;

  state_t        state;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;
  logic [1:0]    scl_q, sda_q;
  logic          scl_s, sda_s, lines_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
    end
  end

  assign scl_s         = scl_q[1];
  assign sda_s         = sda_q[1];
  assign lines_high    = scl_s & sda_s;
  assign scl_drive_low = (state == S_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tcnt     <= '0;
      pcnt     <= '0;
      done     <= 1'b0;
      err_busy <= 1'b0;
      last_scl <= 1'b1;
      last_sda <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            tcnt <= '0;
            pcnt <= '0;
            if (lines_high) begin
              done     <= 1'b1;
              err_busy <= 1'b0;
              last_scl <= 1'b1;
              last_sda <= 1'b1;
            end else begin
              state <= S_LOW;
            end
          end
        end
        S_LOW: begin
          if (tick) begin
            if (tcnt == TW'(LOW_TICKS - 1)) begin
              tcnt  <= '0;
              state <= S_HIGH;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_HIGH: begin
          if (tick) begin
            if (tcnt == TW'(HIGH_TICKS - 1)) begin
              tcnt <= '0;
              if (pcnt == PW'(PULSE_COUNT - 1)) begin
                state <= S_POLL;
              end else begin
                pcnt  <= pcnt + 1'b1;
                state <= S_LOW;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          if (lines_high) begin
            done     <= 1'b1;
            err_busy <= 1'b0;
            last_scl <= 1'b1;
            last_sda <= 1'b1;
            state    <= S_IDLE;
          end else if (tick) begin
            if (tcnt == TW'(TIMEOUT_TICKS - 1)) begin
              done     <= 1'b1;
              err_busy <= 1'b1;
              last_scl <= scl_s;
              last_sda <= sda_s;
              state    <= S_IDLE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err_busy) && $stable(last_scl) && $stable(last_sda)));

  a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < PW'(PULSE_COUNT));

  a_r3_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOW) |-> (tcnt < TW'(LOW_TICKS)));

  a_r6_no_drive_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scl_drive_low);

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && start) |=> (state == S_LOW || state == S_HIGH));

endmodule

// File: tb/i2c_bus_clear_bench.sv
module i2c_bus_clear_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 9;
  localparam int LT = 3;
  localparam int HT = 2;
  localparam int TO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start = 1'b0;
  logic stuck_scl = 1'b0;
  logic stuck_sda = 1'b0;
  logic scl_in, sda_in;
  logic scl_drive_low, done, err_busy, last_scl, last_sda;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign scl_in = !scl_drive_low && !stuck_scl;
  assign sda_in = !stuck_sda;

  i2c_bus_clear #(
    .PULSE_COUNT(NP), .LOW_TICKS(LT), .HIGH_TICKS(HT), .TIMEOUT_TICKS(TO)
  ) u_i2c_bus_clear (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .scl_in(scl_in), .sda_in(sda_in), .scl_drive_low(scl_drive_low),
    .done(done), .err_busy(err_busy), .last_scl(last_scl), .last_sda(last_sda)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rel: 1..9 release after that pulse, 10 release mid-poll, 11 never
  task automatic run_case(input int sc, input int sd, input int rel,
                          input int tp, input int inj);
    int pulses = 0, lowt = 0, hight = 0, postt = 0, iter = 0;
    int bad_low = 0, bad_high = 0, dones = 0, tc = 0;
    logic prev_oe = 1'b0, injected = 1'b0;
    logic clean, exp_err, exp_scl, exp_sda, e_err, e_scl, e_sda;
    clean   = (sc == 0) && (sd == 0);
    exp_err = !clean && (rel == 11);
    exp_scl = exp_err ? (sc == 0) : 1'b1;
    exp_sda = exp_err ? (sd == 0) : 1'b1;
    @(negedge clk);
    tick = 1'b0;
    stuck_scl = (sc != 0);
    stuck_sda = (sd != 0);
    repeat (4) @(negedge clk);
    start = 1'b1;
    while (iter < 5000) begin
      @(negedge clk);
      iter++;
      start = 1'b0;
      if (done) begin
        dones++;
        break;
      end
      if (scl_drive_low && !prev_oe) begin
        if (pulses > 0 && hight != HT) bad_high++;
        pulses++;
        lowt = 0;
      end
      if (!scl_drive_low && prev_oe) begin
        if (lowt != LT) bad_low++;
        hight = 0;
        postt = 0;
        if (pulses == rel) begin
          stuck_scl = 1'b0;
          stuck_sda = 1'b0;
        end
      end
      prev_oe = scl_drive_low;
      tick = ((tc % tp) == tp - 1);
      tc++;
      if (tick) begin
        if (scl_drive_low) lowt++;
        else if (pulses > 0 && pulses < NP) hight++;
        else if (pulses == NP) postt++;
      end
      if (rel == 10 && pulses == NP && postt == HT + TO / 2) begin
        stuck_scl = 1'b0;
        stuck_sda = 1'b0;
      end
      if (inj != 0 && pulses == 3 && !injected) begin
        start = 1'b1;
        injected = 1'b1;
      end
    end
    tick = 1'b0;
    chk("R8 done seen", dones, 1);
    if (clean) begin
      chk("R1 done latency", iter, 1);
      chk("R1 no pulses", pulses, 0);
      chk("R1 no error", err_busy, 0);
    end else begin
      chk("R2 pulse count", pulses, NP);
      chk("R3 low phase length", bad_low, 0);
      chk("R4 release phase length", bad_high, 0);
      if (exp_err) begin
        chk("R6 timeout ticks", postt, HT + TO);
        chk("R6 error flag", err_busy, 1);
      end else begin
        chk("R5 no error", err_busy, 0);
      end
      chk(exp_err ? "R6 last scl" : "R5 last scl", last_scl, exp_scl);
      chk(exp_err ? "R6 last sda" : "R5 last sda", last_sda, exp_sda);
    end
    e_err = err_busy; e_scl = last_scl; e_sda = last_sda;
    stuck_scl = 1'b0;
    stuck_sda = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
      chk("R8 result held", {err_busy, last_scl, last_sda}, {e_err, e_scl, e_sda});
    end
    if (inj != 0) begin
      chk("R7 start ignored mid-run", dones, 1);
      chk("R7 pulse train intact", pulses, NP);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset done", done, 0);
    chk("R8 reset err", err_busy, 0);
    chk("R2 reset drive", scl_drive_low, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int tp = 1; tp <= 3; tp++) begin
      run_case(0, 0, 11, tp, 0);
      for (int sc = 0; sc <= 1; sc++)
        for (int sd = 0; sd <= 1; sd++) begin
          if (sc == 0 && sd == 0) continue;
          run_case(sc, sd, 1, tp, 0);
          run_case(sc, sd, 5, tp, 1);
          run_case(sc, sd, 9, tp, 0);
          run_case(sc, sd, 10, tp, 1);
          run_case(sc, sd, 11, tp, tp % 2);
        end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule